// File: doc/BRIEF.md
# Priority-Level Interrupt Resolver

This block gathers up to 32 interrupt lines into a pending register and keeps a per-line enable mask. The pending and enable registers are combined into a candidate set. The candidate set is sorted into priority levels that are fixed when the block is built. The block then drives an interrupt request to the processor, together with the number of the highest level that lies above the processor's current threshold. Each line is built either as level-sensitive or as edge-latched. Timer comparator match signals can be routed onto chosen lines.

Software reaches three registers through a small write port. The enable mask is written whole. Latched edge lines are set by a write-one-to-set register and cleared by a write-one-to-clear register. The processor supplies its current threshold as an input, and the block reports the winning level with a one-cycle registered delay.

Top module: `irq_level_resolver`

## Requirements
- R1: A line takes part in resolution only when both its pending bit and its enable bit are set. A write with `reg_sel_i` = 2'd0 replaces the whole enable mask with `reg_wdata_i`. Lines whose enable bit is 0 never cause a request.
- R2: Among the levels strictly greater than `threshold_i` that hold at least one candidate, the highest one is reported on `irq_level_o`, and `irq_req_o` is 1. With the default build, line i belongs to level (i mod 6) + 1, and levels run from 1 to 6.
- R3: When no level strictly greater than `threshold_i` holds a candidate, `irq_level_o` is 0 and `irq_req_o` is 0. A threshold equal to the candidate's level counts as no candidate.
- R4: A high input line sets its pending bit, whatever the line type.
- R5: A pending bit on a level-sensitive line (lines 0 to 15 by default) follows its input, so it clears when the input goes low.
- R6: A pending bit on an edge-type line (lines 16 to 23 by default) stays set after its input goes low, until software clears it.
- R7: Lines at index N_IRQ or above (24 to 31 by default) never become pending. This holds for input lines, for software set writes and for timer matches routed to those lines.
- R8: A match on timer comparator k asserts the line routed to it. By default comparator 0 drives line 7, comparator 1 drives line 16 and comparator 2 drives line 30.
- R9: A write with `reg_sel_i` = 2'd1 sets the edge-type pending bits selected by ones in `reg_wdata_i`. A write with `reg_sel_i` = 2'd2 clears them. Neither write has any effect on level-sensitive lines.
- R10: When an edge-type input is high in the same cycle as a clear write to its bit, the bit stays pending.
- R11: `irq_req_o` and `irq_level_o` are registered. They reflect a change of inputs, register writes or threshold from the first rising clock edge that samples the change. Reset clears the pending register, the enable register and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | N_LINES | Raw interrupt inputs |
| timer_match_i | input | N_TIMERS | Timer comparator match pulses |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 set, 2 clear, 3 none |
| reg_wdata_i | input | N_LINES | Register write data |
| threshold_i | input | LVL_W | Current processor interrupt level |
| irq_req_o | output | 1 | Interrupt request |
| irq_level_o | output | LVL_W | Winning level, 0 when idle |

## Verification
Two functions can act on one edge-type bit in the same cycle: the hardware input that latches it, and the software clear that removes it. The bench provokes this by holding line 17 high during the cycle in which a clear write names bit 17. It then checks that the level-6 request is still reported, and that a clear issued after the input has dropped does remove it. A timer match and a software set are also aimed at unimplemented lines, and the bench checks that no request appears.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;
  localparam int unsigned LINES_DEF  = 32;
  localparam int unsigned LEVELS_DEF = 6;
  localparam int unsigned LVL_W_DEF  = 3;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_SET    = 2'd1,
    SEL_CLEAR  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // default map: line i -> level (i mod LEVELS) + 1
  function automatic logic [LINES_DEF*LVL_W_DEF-1:0] spread_levels();
    logic [LINES_DEF*LVL_W_DEF-1:0] r;
    r = '0;
    for (int i = 0; i < int'(LINES_DEF); i++) begin
      r[i*LVL_W_DEF +: LVL_W_DEF] = LVL_W_DEF'((i % int'(LEVELS_DEF)) + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
  parameter int unsigned N_LINES  = 32,
  parameter int unsigned N_IRQ    = 24,
  parameter int unsigned N_TIMERS = 3,
  parameter logic [N_TIMERS*8-1:0] TIMER_LINE = {8'd30, 8'd16, 8'd7}
) (
  input  logic [N_LINES-1:0]  lines_i,
  input  logic [N_TIMERS-1:0] timer_i,
  output logic [N_LINES-1:0]  raw_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    if (i < N_IRQ) begin : g_live
      logic t_hit;
      always_comb begin
        t_hit = 1'b0;
        for (int t = 0; t < int'(N_TIMERS); t++) begin
          if (TIMER_LINE[t*8 +: 8] == 8'(i)) t_hit = t_hit | timer_i[t];
        end
      end
      assign raw_o[i] = lines_i[i] | t_hit;
    end else begin : g_dead
      assign raw_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg
  import irq_lvl_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned N_IRQ   = 24,
  parameter logic [N_LINES-1:0] EDGE_LINES = 32'hFFFF_0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] raw_i,
  input  logic               we_i,
  input  reg_sel_e           sel_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] pend_q_o,
  output logic [N_LINES-1:0] en_q_o,
  output logic [N_LINES-1:0] pend_nxt_o,
  output logic [N_LINES-1:0] en_nxt_o
);
  localparam logic [N_LINES-1:0] VALID_M = (N_IRQ >= N_LINES) ? {N_LINES{1'b1}}
                                         : N_LINES'((64'd1 << N_IRQ) - 64'd1);
  localparam logic [N_LINES-1:0] EDGE_V = EDGE_LINES & VALID_M;
  localparam logic [N_LINES-1:0] LVL_V  = ~EDGE_LINES & VALID_M;

  logic [N_LINES-1:0] pend_q, en_q, set_w, clr_w, edge_nxt;

  always_comb begin
    set_w      = (we_i && sel_i == SEL_SET)   ? wdata_i : '0;
    clr_w      = (we_i && sel_i == SEL_CLEAR) ? wdata_i : '0;
    en_nxt_o   = (we_i && sel_i == SEL_ENABLE) ? wdata_i : en_q;
    // input set wins over a same-cycle clear
    edge_nxt   = ((pend_q & ~clr_w) | set_w | raw_i) & EDGE_V;
    pend_nxt_o = edge_nxt | (raw_i & LVL_V);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_nxt_o;
      en_q   <= en_nxt_o;
    end
  end

  assign pend_q_o = pend_q;
  assign en_q_o   = en_q;

  a_r4_raw_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raw_i) |=> ((pend_q & $past(raw_i)) == $past(raw_i)));

  a_r5_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(raw_i & LVL_V) || |(pend_q & LVL_V)) |=> (((pend_q ^ $past(raw_i)) & LVL_V) == '0));

  a_r6_edge_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && sel_i == SEL_CLEAR) |=> ((pend_q & $past(pend_q) & EDGE_V) == ($past(pend_q) & EDGE_V)));

  a_r7_dead_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~VALID_M) == '0);
endmodule

// File: rtl/irq_level_mask.sv
module irq_level_mask #(
  parameter int unsigned N_LINES  = 32,
  parameter int unsigned N_LEVELS = 6,
  parameter int unsigned LVL_W    = 3,
  parameter logic [N_LINES*LVL_W-1:0] LINE_LEVEL = irq_lvl_pkg::spread_levels()
) (
  input  logic [N_LINES-1:0]  cand_i,
  output logic [N_LEVELS-1:0] hit_o
);
  for (genvar l = 0; l < N_LEVELS; l++) begin : g_lvl
    logic [N_LINES-1:0] member;
    for (genvar i = 0; i < N_LINES; i++) begin : g_bit
      assign member[i] = (LINE_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(l + 1));
    end
    assign hit_o[l] = |(cand_i & member);
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int unsigned N_LEVELS = 6,
  parameter int unsigned LVL_W    = 3
) (
  input  logic [N_LEVELS-1:0] hit_i,
  input  logic [LVL_W-1:0]    thr_i,
  output logic [LVL_W-1:0]    level_o
);
  // ascending scan, last qualifying level wins = highest
  always_comb begin
    level_o = '0;
    for (int l = 1; l <= int'(N_LEVELS); l++) begin
      if (hit_i[l-1] && (LVL_W'(l) > thr_i)) level_o = LVL_W'(l);
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_lvl_pkg::*;
#(
  parameter int unsigned N_LINES  = 32,
  parameter int unsigned N_IRQ    = 24,
  parameter int unsigned N_LEVELS = 6,
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned N_TIMERS = 3,
  parameter logic [N_LINES*LVL_W-1:0] LINE_LEVEL = spread_levels(),
  parameter logic [N_LINES-1:0]       EDGE_LINES = 32'hFFFF_0000,
  parameter logic [N_TIMERS*8-1:0]    TIMER_LINE = {8'd30, 8'd16, 8'd7}
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_LINES-1:0]  irq_lines_i,
  input  logic [N_TIMERS-1:0] timer_match_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [N_LINES-1:0]  reg_wdata_i,
  input  logic [LVL_W-1:0]    threshold_i,
  output logic                irq_req_o,
  output logic [LVL_W-1:0]    irq_level_o
);
  logic [N_LINES-1:0]  raw, pend_q, en_q, pend_nxt, en_nxt;
  logic [N_LEVELS-1:0] hit;
  logic [LVL_W-1:0]    win, level_q;
  logic                req_q;

  irq_src_map #(
    .N_LINES(N_LINES), .N_IRQ(N_IRQ), .N_TIMERS(N_TIMERS), .TIMER_LINE(TIMER_LINE)
  ) u_src (
    .lines_i(irq_lines_i), .timer_i(timer_match_i), .raw_o(raw)
  );

  irq_pending_reg #(
    .N_LINES(N_LINES), .N_IRQ(N_IRQ), .EDGE_LINES(EDGE_LINES)
  ) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(raw), .we_i(reg_we_i),
    .sel_i(reg_sel_e'(reg_sel_i)), .wdata_i(reg_wdata_i),
    .pend_q_o(pend_q), .en_q_o(en_q), .pend_nxt_o(pend_nxt), .en_nxt_o(en_nxt)
  );

  // resolve on next-state so the outputs lag the cause by one edge
  irq_level_mask #(
    .N_LINES(N_LINES), .N_LEVELS(N_LEVELS), .LVL_W(LVL_W), .LINE_LEVEL(LINE_LEVEL)
  ) u_mask (
    .cand_i(pend_nxt & en_nxt), .hit_o(hit)
  );

  irq_level_pick #(.N_LEVELS(N_LEVELS), .LVL_W(LVL_W)) u_pick (
    .hit_i(hit), .thr_i(threshold_i), .level_o(win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      req_q   <= 1'b0;
    end else begin
      level_q <= win;
      req_q   <= (win != '0);
    end
  end

  assign irq_req_o   = req_q;
  assign irq_level_o = level_q;

  a_r1_needs_cand: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (|(pend_q & en_q)));

  a_r2_above_thr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_level_o > $past(threshold_i)));

  a_r3_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o == '0) |-> !irq_req_o);

  a_r3_no_cand_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & en_q) == '0) |-> !irq_req_o);
endmodule

// File: tb/irq_level_resolver_test.sv
`timescale 1ns/1ps
module irq_level_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lines = '0;
  logic [2:0]  tmr = '0;
  logic        we = 1'b0;
  logic [1:0]  sel = 2'd3;
  logic [31:0] wd = '0;
  logic [2:0]  thr = '0;
  logic        req;
  logic [2:0]  lvl;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_pend = '0, m_en = '0;
  logic [3:0]  exp_q[$];
  string       tag_q[$];

  irq_level_resolver uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines), .timer_match_i(tmr),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wd), .threshold_i(thr),
    .irq_req_o(req), .irq_level_o(lvl)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got req/level %b/%0d expected %b/%0d", tag, act[3], act[2:0], exp[3], exp[2:0]);
    end
  endtask

  // driver: apply one cycle of stimulus, advance the model, queue the result
  task automatic step(input logic [31:0] l, input logic [2:0] t, input bit w,
                      input logic [1:0] s, input logic [31:0] d, input logic [2:0] th,
                      input string tag);
    logic [31:0] raw, setw, clrw, edg, cand;
    int best;
    @(negedge clk);
    lines = l; tmr = t; we = w; sel = s; wd = d; thr = th;
    raw = l;
    if (t[0]) raw[7] = 1'b1;
    if (t[1]) raw[16] = 1'b1;
    if (t[2]) raw[30] = 1'b1;
    raw &= 32'h00FF_FFFF;
    setw = (w && s == 2'd1) ? d : '0;
    clrw = (w && s == 2'd2) ? d : '0;
    if (w && s == 2'd0) m_en = d;
    edg = ((m_pend & ~clrw) | setw | raw) & 32'h00FF_0000;
    m_pend = edg | (raw & 32'h0000_FFFF);
    cand = m_pend & m_en;
    best = 0;
    for (int i = 0; i < 32; i++)
      if (cand[i] && ((i % 6) + 1) > int'(th) && ((i % 6) + 1) > best) best = (i % 6) + 1;
    exp_q.push_back({best != 0, 3'(best)});
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({req, lvl} == e, tg, {req, lvl}, e);
      end
    end
  end

  initial begin
    #(8ns * 20000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk({req, lvl} == 4'd0, "R11 reset", {req, lvl}, 4'd0);
    @(negedge clk); rst_n = 1'b1;

    step('0, '0, 1, 2'd0, 32'hFFFF_FFFF, 3'd0, "R1 enable all");
    step(32'h1, '0, 0, 2'd3, '0, 3'd0, "R4 line0 level1");
    step(32'h21, '0, 0, 2'd3, '0, 3'd0, "R2 line5 level6 wins");
    step(32'h21, '0, 0, 2'd3, '0, 3'd6, "R3 threshold equal");
    step(32'h21, '0, 0, 2'd3, '0, 3'd5, "R2 above threshold");
    step(32'h6, '0, 0, 2'd3, '0, 3'd0, "R2 line2 level3 over line1");
    step(32'h6, '0, 0, 2'd3, '0, 3'd3, "R3 level3 not above 3");
    step(32'h6, '0, 0, 2'd3, '0, 3'd2, "R2 level3 above 2");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R5 level lines drop");
    step(32'h0002_0000, '0, 0, 2'd3, '0, 3'd0, "R4 edge line17 set");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R6 edge line17 held");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R6 edge line17 still held");
    step('0, '0, 1, 2'd2, 32'h0002_0000, 3'd0, "R9 clear line17");
    step(32'h0002_0000, '0, 1, 2'd2, 32'h0002_0000, 3'd0, "R10 input beats clear");
    step('0, '0, 1, 2'd2, 32'h0002_0000, 3'd0, "R10 clear after drop");
    step('0, '0, 1, 2'd1, 32'h0000_0008, 3'd0, "R9 set on level line ignored");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R9 level line stays clear");
    step('0, '0, 1, 2'd1, 32'h0008_0000, 3'd0, "R9 set edge line19");
    step('0, '0, 1, 2'd2, 32'hFFFF_FFFF, 3'd0, "R9 clear all edges");
    step(32'h20, '0, 1, 2'd0, 32'h0, 3'd0, "R1 disabled line");
    step(32'h20, '0, 1, 2'd0, 32'h20, 3'd0, "R1 enable line5");
    step('0, '0, 1, 2'd0, 32'hFFFF_FFFF, 3'd0, "R1 enable all again");
    step(32'h1000_0000, '0, 0, 2'd3, '0, 3'd0, "R7 line28 ignored");
    step('0, '0, 1, 2'd1, 32'hFF00_0000, 3'd0, "R7 set on dead lines");
    step('0, 3'b001, 0, 2'd3, '0, 3'd0, "R8 timer0 line7");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R8 timer0 line7 released");
    step('0, 3'b010, 0, 2'd3, '0, 3'd0, "R8 timer1 line16");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R8 timer1 line16 latched");
    step('0, '0, 1, 2'd2, 32'h0001_0000, 3'd0, "R9 clear line16");
    step('0, 3'b100, 0, 2'd3, '0, 3'd0, "R7 R8 timer2 dead line");
    step(32'h0000_0800, '0, 0, 2'd3, '0, 3'd0, "R11 line11 level6");
    step('0, '0, 0, 2'd3, '0, 3'd0, "R11 one cycle release");

    // reset mid-run clears state
    @(negedge clk); rst_n = 1'b0; m_pend = '0; m_en = '0;
    lines = 32'h0001_0001;
    @(posedge clk); #2;
    chk({req, lvl} == 4'd0, "R11 reset mid-run", {req, lvl}, 4'd0);
    @(negedge clk); rst_n = 1'b1;
    step(32'h1, '0, 0, 2'd3, '0, 3'd0, "R11 enable cleared by reset");

    step('0, '0, 0, 2'd3, '0, 3'd0, "R5 idle");
    repeat (3) @(posedge clk);
    #3;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule